// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit adder. It takes two operands and a carry-in and returns their sum and carry-out within the same evaluation. There is no register anywhere on the path. The operand width is split into four groups of four bits. Each group forms per-bit generate (a AND b) and propagate (a OR b) terms. It then expands every internal carry directly from those terms and the group carry-in, in two-level sum-of-products form, so no carry has to wait for its neighbour.

Each group also reports a group generate and a group propagate. A second lookahead unit, with the same structure as the one inside each group, turns those terms and the adder's carry-in into the carry entering every group. The sums are formed last, as the XOR of the two operand bits and the bit carry.

The adder also exports its own whole-width generate and propagate. A parent lookahead unit can therefore treat four of these adders as groups and build a 64-bit adder without a ripple between them.

Top module: `cla_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + carry_in` for every input combination.
- R2: `carry_out` equals bit 16 of the 17-bit value `a_in + b_in + carry_in`.
- R3: `blk_gen` is 1 exactly when `a_in + b_in` (carry-in taken as 0) is 65536 or more.
- R4: `blk_prop` is 1 exactly when every bit position has at least one operand bit set, that is when `(a_in | b_in)` is 16'hFFFF.
- R5: `carry_out` always equals `blk_gen | (blk_prop & carry_in)`, so that the adder can be used as a group of a larger lookahead tree.
- R6: A carry entering at bit 0 crosses all four group boundaries: `a_in`=16'hFFFF, `b_in`=0, `carry_in`=1 gives `sum_out`=0, `carry_out`=1, `blk_gen`=0, `blk_prop`=1.
- R7: A carry generated in the top bit of one group reaches the group above it. For each group k, `a_in` = `b_in` = 2^(4k+3) gives `sum_out` = 2^(4k+4) mod 65536, with `carry_out` set only for k=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum, modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_gen | output | 1 | Whole-width generate (carry out with carry-in 0) |
| blk_prop | output | 1 | Whole-width propagate (AND of all per-bit OR terms) |

## Verification
The adder has no state, so any wrong term inside it shows at the ports in the same evaluation as the input that exercises it. A wrong per-bit generate or propagate, or a wrong expanded carry, flips the sum bit above the faulty position. If the fault sits in a group's top bit, it also flips the carry into the next group. Faults in the second-level unit appear as whole groups of sum bits off by one, or as a wrong `carry_out`, `blk_gen` or `blk_prop`. Directed patterns that place a carry exactly at each group boundary are used alongside random operands, so that such faults are exposed rather than masked.

// File: rtl/cla_pkg.sv
// Shared sizing for the two-level lookahead adder.
// Assumes the total width is an exact multiple of the group width.
package cla_pkg;
    localparam int unsigned CLA_GROUP_W    = 4;
    localparam int unsigned CLA_NUM_GROUPS = 4;
    localparam int unsigned CLA_WIDTH      = CLA_GROUP_W * CLA_NUM_GROUPS;
endpackage : cla_pkg

// File: rtl/cla_carry_unit.sv
// Lookahead carry unit: from N generate/propagate pairs and a carry-in it
// forms every carry in flat sum-of-products form (no chain between
// positions), plus the combined generate/propagate of all N positions.
// The same unit serves at bit level inside a group and at group level.
// Assumes propagate may be the OR form; it is never reused for sums.
module cla_carry_unit #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin_i,
    output logic [N-1:0] carry_o,   // carry into position i
    output logic         cout_o,    // carry out of position N-1
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    logic [N:0] cy;

    // Expand every carry from g, p and cin alone (two-level form).
    always_comb begin
        cy[0] = cin_i;
        for (int i = 0; i < N; i++) begin
            logic acc;
            logic pterm;
            pterm = cin_i;
            for (int j = 0; j <= i; j++) pterm = pterm & prop_i[j];
            acc = pterm;
            for (int j = 0; j <= i; j++) begin
                logic t;
                t = gen_i[j];
                for (int k = j + 1; k <= i; k++) t = t & prop_i[k];
                acc = acc | t;
            end
            cy[i+1] = acc;
        end
    end

    // Combined generate: the carry out when the carry-in is zero.
    always_comb begin
        grp_gen_o = 1'b0;
        for (int j = 0; j < N; j++) begin
            logic t;
            t = gen_i[j];
            for (int k = j + 1; k < N; k++) t = t & prop_i[k];
            grp_gen_o = grp_gen_o | t;
        end
    end

    // Combined propagate: every position passes a carry.
    assign grp_prop_o = &prop_i;

    assign carry_o = cy[N-1:0];
    assign cout_o  = cy[N];

    // Each flat carry must agree with the rippled recurrence.
    for (genvar i = 0; i < N; i++) begin : g_rec
        always_comb begin
            // R2
            carry_rec_chk: assert (cy[i+1] == (gen_i[i] | (prop_i[i] & cy[i])))
                else $error("carry recurrence broken at position %0d", i);
        end
    end

    // Carry out must follow from the combined terms.
    always_comb begin
        // R5
        grp_terms_chk: assert (cout_o == (grp_gen_o | (grp_prop_o & cin_i)))
            else $error("carry out disagrees with group generate/propagate");
    end
endmodule : cla_carry_unit

// File: rtl/cla_group.sv
// One lookahead group of W bits: per-bit generate (AND) and propagate (OR),
// internal carries from a flat lookahead unit, sums as a^b^carry.
// Assumes the group carry-in comes from a higher-level lookahead unit.
module cla_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W-1:0] half;
    logic [W-1:0] carry;
    logic         cout;

    // Per-bit terms; the XOR is kept apart from the OR propagate.
    assign gen  = a_i & b_i;
    assign prop = a_i | b_i;
    assign half = a_i ^ b_i;

    cla_carry_unit #(.N(W)) u_carry (
        .gen_i      (gen),
        .prop_i     (prop),
        .cin_i      (cin_i),
        .carry_o    (carry),
        .cout_o     (cout),
        .grp_gen_o  (grp_gen_o),
        .grp_prop_o (grp_prop_o)
    );

    // Sum is formed last from the bit carries.
    assign sum_o = half ^ carry;

    // Group result must match arithmetic on this slice.
    always_comb begin
        // R1
        grp_sum_chk: assert ({cout, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
            else $error("group sum mismatch");
    end
endmodule : cla_group

// File: rtl/cla_adder.sv
// Two-level carry-lookahead adder: NUM_GROUPS groups of GROUP_W bits,
// group carries formed by a second lookahead unit from the group terms.
// Exports whole-width generate/propagate for nesting in a larger tree.
// Purely combinational; assumes no clock or reset is needed.
module cla_adder
    import cla_pkg::*;
#(
    parameter int unsigned GROUP_W    = CLA_GROUP_W,
    parameter int unsigned NUM_GROUPS = CLA_NUM_GROUPS,
    localparam int unsigned WIDTH     = GROUP_W * NUM_GROUPS
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             blk_gen,
    output logic             blk_prop
);
    logic [NUM_GROUPS-1:0] g_gen;
    logic [NUM_GROUPS-1:0] g_prop;
    logic [NUM_GROUPS-1:0] g_cin;

    // First level: one lookahead group per slice.
    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
        cla_group #(.W(GROUP_W)) u_grp (
            .a_i        (a_in[k*GROUP_W +: GROUP_W]),
            .b_i        (b_in[k*GROUP_W +: GROUP_W]),
            .cin_i      (g_cin[k]),
            .sum_o      (sum_out[k*GROUP_W +: GROUP_W]),
            .grp_gen_o  (g_gen[k]),
            .grp_prop_o (g_prop[k])
        );
    end

    // Second level: group carries from group generate/propagate.
    cla_carry_unit #(.N(NUM_GROUPS)) u_top (
        .gen_i      (g_gen),
        .prop_i     (g_prop),
        .cin_i      (carry_in),
        .carry_o    (g_cin),
        .cout_o     (carry_out),
        .grp_gen_o  (blk_gen),
        .grp_prop_o (blk_prop)
    );

    // Whole-width result against plain arithmetic.
    always_comb begin
        // R1
        sum_value_chk: assert ({carry_out, sum_out} ==
                ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in}))
            else $error("adder result mismatch");
        // R4
        blk_prop_chk: assert (blk_prop == (&(a_in | b_in)))
            else $error("whole-width propagate mismatch");
    end
endmodule : cla_adder

// File: tb/cla_adder_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random operands,
// compared against expected values from bench functions.
module cla_adder_tb_top;
    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         blk_gen;
    logic         blk_prop;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    cla_adder dut_i (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .blk_gen   (blk_gen),
        .blk_prop  (blk_prop)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    function automatic logic [W:0] f_total(logic [W-1:0] a, logic [W-1:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endfunction

    function automatic logic f_gen(logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[W];
    endfunction

    function automatic logic f_prop(logic [W-1:0] a, logic [W-1:0] b);
        return (a | b) == {W{1'b1}};
    endfunction

    task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h (a=%h b=%h cin=%b)", req, act, exp, a_in, b_in, carry_in);
        end
    endtask

    // Drive on the falling edge, check just before the rising edge.
    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic c);
        logic [W:0] t;
        @(negedge clk);
        a_in = a; b_in = b; carry_in = c;
        #5;
        t = f_total(a, b, c);
        chk("R1", {1'b0, sum_out}, {1'b0, t[W-1:0]});
        chk("R2", {{W{1'b0}}, carry_out}, {{W{1'b0}}, t[W]});
        chk("R3", {{W{1'b0}}, blk_gen}, {{W{1'b0}}, f_gen(a, b)});
        chk("R4", {{W{1'b0}}, blk_prop}, {{W{1'b0}}, f_prop(a, b)});
        chk("R5", {{W{1'b0}}, carry_out}, {{W{1'b0}}, f_gen(a, b) | (f_prop(a, b) & c)});
    endtask

    initial begin
        void'($urandom(32'd1234));
        // Reset state: zero operands give all-zero outputs.
        repeat (2) @(negedge clk);
        #5;
        chk("R1 reset", {1'b0, sum_out}, '0);
        chk("R2 reset", {{W{1'b0}}, carry_out}, '0);
        chk("R3 reset", {{W{1'b0}}, blk_gen}, '0);
        chk("R4 reset", {{W{1'b0}}, blk_prop}, '0);
        rst_n = 1'b1;

        // R6: carry-in rippling through every group.
        apply(16'hFFFF, 16'h0000, 1'b1);
        chk("R6 sum", {1'b0, sum_out}, '0);
        chk("R6 cout", {{W{1'b0}}, carry_out}, {{W{1'b0}}, 1'b1});
        chk("R6 gen", {{W{1'b0}}, blk_gen}, '0);
        chk("R6 prop", {{W{1'b0}}, blk_prop}, {{W{1'b0}}, 1'b1});
        apply(16'hFFFF, 16'h0001, 1'b0);
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        apply(16'h0000, 16'h0000, 1'b1);
        apply(16'h8000, 16'h8000, 1'b0);
        apply(16'hAAAA, 16'h5555, 1'b1);

        // R7: a generate in the top bit of each group reaches the next.
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] v;
            v = 16'(1) << (4 * k + 3);
            apply(v, v, 1'b0);
            chk("R7 sum", {1'b0, sum_out}, {1'b0, 16'(32'(1) << (4 * k + 4))});
            chk("R7 cout", {{W{1'b0}}, carry_out}, {{W{1'b0}}, (k == 3)});
        end
        // Carry entering each group through a run of propagates.
        for (int k = 1; k < 4; k++) begin
            logic [W-1:0] v;
            v = 16'((32'(1) << (4 * k)) - 1);
            apply(v, 16'h0000, 1'b1);
            chk("R7 run", {1'b0, sum_out}, {1'b0, 16'(32'(1) << (4 * k))});
        end

        // Random operands.
        for (int n = 0; n < 3000; n++) begin
            apply(16'($urandom()), 16'($urandom()), 1'($urandom()));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule : cla_adder_tb_top